// File: doc/BRIEF.md
# Bit-manipulating 64-bit integer ALU

This block is a 64-bit integer arithmetic and logic unit for an execution pipeline. It covers full-width and 32-bit word arithmetic, shifts and rotates, single-bit manipulation, shift-and-add address arithmetic, min/max and set-less-than compares, plain and inverted-operand logic, byte-wise OR-combine, byte and halfword sign extension, byte reversal, and conditional-branch evaluation. A 7-bit operation code selects the function, and its top three bits select the group.

The datapath is combinational. It ends in a single register stage, so a request presented with `valid_i` high gives its result one clock later with `valid_o` high. The result register and the branch flag hold their values while no request is presented. An operation code that names no function gives a zero result and a cleared branch flag.

Top module: `bm_alu64`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. `result_o` and `taken_o` load only in cycles where `valid_i` is high and otherwise hold their values. Reset clears all three outputs.
- R2: Full-width shifts use `src_b_i[5:0]` as the amount: sll 0000001, srl 0000101, sra 0000111. The rotates rol 0001001 and ror 0001011 rotate across all 64 bits.
- R3: The single-bit operations use idx = `src_b_i[5:0]`. Clear (0000010) gives a AND NOT(1<<idx). Set (0000011) gives a OR (1<<idx). Invert (0000100) gives a XOR (1<<idx). Extract (0000110) returns bit idx of a in bit 0, with all other bits zero.
- R4: Word add (0010000) and word subtract (0010010) work on the low 32 bits. Bit 31 of the 32-bit result is copied into bits 63:32.
- R5: The word shifts sllw 0011000, srlw 0011001 and sraw 0011010 shift `src_a_i[31:0]` by `src_b_i[4:0]`. Bit 31 of the 32-bit result is copied into bits 63:32.
- R6: add (0100001) gives a+b. adduw (0100000) gives zext(a[31:0])+b. sh1add 0101001, sh2add 0101011 and sh3add 0101101 give (a<<n)+b for n = 1, 2, 3. Their uw forms 0101000, 0101010 and 0101100 shift zext(a[31:0]) instead of a.
- R7: sub (0110000) gives a-b. Unsigned less-than (0110001) and signed less-than (0110010) return 1 or 0.
- R8: maxu 0110100 and minu 0110101 compare unsigned. max 0110110 and min 0110111 compare as two's complement.
- R9: and 1000000, andn 1000001 (a AND NOT b), or 1000010, orn 1000011, xor 1000100 and xnor 1000101 are the logic operations. orc.b (1000110) sets each byte of a to 0xFF if any of its bits is set, and to 0x00 otherwise.
- R10: Byte sign extension is 1001000, halfword sign extension is 1001010, and byte reversal of a is 1010001.
- R11: For opcodes 110xxxx, bits [3:1] select the function: 000 and, 001 or, 010 xor, 011 orc.b. When bit 0 is 0 the result is bit 0 of that function's output, zero-extended. When bit 0 is 1 it is the low 16 bits, zero-extended. Codes with bit 3 set are unrecognised.
- R12: Opcodes 111xxx0 are branches. Bits [3:2] select the comparison: 00 equal, 10 signed less-than, 11 unsigned less-than. Bit 1 inverts the outcome. The outcome drives `taken_o`, and `result_o` is zero.
- R13: Any other opcode, including branch codes with bits [3:2] = 01 or bit 0 set, gives `result_o` = 0 and `taken_o` = 0. `taken_o` is never set by a non-branch opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 7 | Operation code |
| src_a_i | input | 64 | First operand |
| src_b_i | input | 64 | Second operand, shift amount or bit index |
| valid_o | output | 1 | Result valid, one clock after `valid_i` |
| result_o | output | 64 | Registered result |
| taken_o | output | 1 | Registered branch outcome |

## Verification
The hardest cases to reach from the ports are the edges of the amount and sign fields. These are rotates by zero, shifts by 63, word shifts whose amount has bit 5 set but must be ignored, and signed compares in which exactly one operand is the most negative value. Random operands rarely produce these. The stimulus therefore sweeps all 128 opcodes over a fixed grid of corner pairs (zero, all-ones, most negative value, amounts 0, 31, 32 and 63) before the random pairs. It also runs idle cycles with changed inputs so that the hold behaviour can be observed.

// File: rtl/bm_alu_pkg.sv
package bm_alu_pkg;
  localparam int XLEN = 64;
  localparam int WLEN = 32;
  localparam int OPW  = 7;
  localparam int SHW  = $clog2(XLEN);
  localparam int WSHW = $clog2(WLEN);
  localparam int NBYTE = XLEN / 8;

  typedef logic [OPW-1:0]  op_t;
  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    GRP_SHIFT = 3'b000,
    GRP_WORD  = 3'b001,
    GRP_ADD   = 3'b010,
    GRP_CMP   = 3'b011,
    GRP_LOG   = 3'b100,
    GRP_PACK  = 3'b101,
    GRP_NARROW = 3'b110,
    GRP_BRANCH = 3'b111
  } grp_e;

  localparam op_t OP_SLL   = 7'b000_0001;
  localparam op_t OP_BCLR  = 7'b000_0010;
  localparam op_t OP_BSET  = 7'b000_0011;
  localparam op_t OP_BINV  = 7'b000_0100;
  localparam op_t OP_SRL   = 7'b000_0101;
  localparam op_t OP_BEXT  = 7'b000_0110;
  localparam op_t OP_SRA   = 7'b000_0111;
  localparam op_t OP_ROL   = 7'b000_1001;
  localparam op_t OP_ROR   = 7'b000_1011;
  localparam op_t OP_ADDW  = 7'b001_0000;
  localparam op_t OP_SUBW  = 7'b001_0010;
  localparam op_t OP_SLLW  = 7'b001_1000;
  localparam op_t OP_SRLW  = 7'b001_1001;
  localparam op_t OP_SRAW  = 7'b001_1010;
  localparam op_t OP_ADDUW = 7'b010_0000;
  localparam op_t OP_ADD   = 7'b010_0001;
  localparam op_t OP_S1AUW = 7'b010_1000;
  localparam op_t OP_S1A   = 7'b010_1001;
  localparam op_t OP_S2AUW = 7'b010_1010;
  localparam op_t OP_S2A   = 7'b010_1011;
  localparam op_t OP_S3AUW = 7'b010_1100;
  localparam op_t OP_S3A   = 7'b010_1101;
  localparam op_t OP_SUB   = 7'b011_0000;
  localparam op_t OP_SLTU  = 7'b011_0001;
  localparam op_t OP_SLT   = 7'b011_0010;
  localparam op_t OP_MAXU  = 7'b011_0100;
  localparam op_t OP_MINU  = 7'b011_0101;
  localparam op_t OP_MAX   = 7'b011_0110;
  localparam op_t OP_MIN   = 7'b011_0111;
  localparam op_t OP_AND   = 7'b100_0000;
  localparam op_t OP_ANDN  = 7'b100_0001;
  localparam op_t OP_OR    = 7'b100_0010;
  localparam op_t OP_ORN   = 7'b100_0011;
  localparam op_t OP_XOR   = 7'b100_0100;
  localparam op_t OP_XNOR  = 7'b100_0101;
  localparam op_t OP_ORCB  = 7'b100_0110;
  localparam op_t OP_SEXTB = 7'b100_1000;
  localparam op_t OP_SEXTH = 7'b100_1010;
  localparam op_t OP_REV8  = 7'b101_0001;

  // narrow-form logic selector (op[3:1] of group 110)
  localparam logic [2:0] NSEL_AND  = 3'b000;
  localparam logic [2:0] NSEL_OR   = 3'b001;
  localparam logic [2:0] NSEL_XOR  = 3'b010;
  localparam logic [2:0] NSEL_ORCB = 3'b011;
endpackage

// File: rtl/bm_alu_shift.sv
module bm_alu_shift
  import bm_alu_pkg::*;
(
  input  op_t   op_i,
  input  word_t a_i,
  input  word_t b_i,
  output word_t res_o,
  output logic  hit_o
);
  logic [SHW-1:0]  sh;
  logic [WSHW-1:0] shw;
  logic [SHW:0]    sh_inv;
  word_t           bit_mask;
  logic [WLEN-1:0] w_sll, w_srl, w_sra;

  assign sh       = b_i[SHW-1:0];
  assign shw      = b_i[WSHW-1:0];
  assign sh_inv   = (SHW+1)'(XLEN) - {1'b0, sh};
  assign bit_mask = word_t'(1) << sh;
  assign w_sll    = a_i[WLEN-1:0] << shw;
  assign w_srl    = a_i[WLEN-1:0] >> shw;
  assign w_sra    = WLEN'($signed(a_i[WLEN-1:0]) >>> shw);

  always_comb begin
    hit_o = 1'b1;
    unique case (op_i)
      OP_SLL:  res_o = a_i << sh;
      OP_SRL:  res_o = a_i >> sh;
      OP_SRA:  res_o = word_t'($signed(a_i) >>> sh);
      OP_ROL:  res_o = (a_i << sh) | (a_i >> sh_inv);
      OP_ROR:  res_o = (a_i >> sh) | (a_i << sh_inv);
      OP_BCLR: res_o = a_i & ~bit_mask;
      OP_BSET: res_o = a_i | bit_mask;
      OP_BINV: res_o = a_i ^ bit_mask;
      OP_BEXT: res_o = word_t'(a_i[sh]);
      OP_SLLW: res_o = {{(XLEN-WLEN){w_sll[WLEN-1]}}, w_sll};
      OP_SRLW: res_o = {{(XLEN-WLEN){w_srl[WLEN-1]}}, w_srl};
      OP_SRAW: res_o = {{(XLEN-WLEN){w_sra[WLEN-1]}}, w_sra};
      default: begin
        res_o = '0;
        hit_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (op_i == OP_BEXT)
      assert_bext_single_bit_R3: assert (res_o[XLEN-1:1] == '0);
  end
endmodule

// File: rtl/bm_alu_arith.sv
module bm_alu_arith
  import bm_alu_pkg::*;
(
  input  op_t   op_i,
  input  word_t a_i,
  input  word_t b_i,
  output word_t res_o,
  output logic  hit_o
);
  word_t           a_uw, diff;
  logic [WLEN-1:0] w_add, w_sub;
  logic            lt_u, lt_s;

  assign a_uw  = {{(XLEN-WLEN){1'b0}}, a_i[WLEN-1:0]};
  assign diff  = a_i - b_i;
  assign w_add = a_i[WLEN-1:0] + b_i[WLEN-1:0];
  assign w_sub = a_i[WLEN-1:0] - b_i[WLEN-1:0];
  assign lt_u  = a_i < b_i;
  assign lt_s  = $signed(a_i) < $signed(b_i);

  always_comb begin
    hit_o = 1'b1;
    unique case (op_i)
      OP_ADDW:  res_o = {{(XLEN-WLEN){w_add[WLEN-1]}}, w_add};
      OP_SUBW:  res_o = {{(XLEN-WLEN){w_sub[WLEN-1]}}, w_sub};
      OP_ADD:   res_o = a_i + b_i;
      OP_ADDUW: res_o = a_uw + b_i;
      OP_S1A:   res_o = (a_i << 1) + b_i;
      OP_S2A:   res_o = (a_i << 2) + b_i;
      OP_S3A:   res_o = (a_i << 3) + b_i;
      OP_S1AUW: res_o = (a_uw << 1) + b_i;
      OP_S2AUW: res_o = (a_uw << 2) + b_i;
      OP_S3AUW: res_o = (a_uw << 3) + b_i;
      OP_SUB:   res_o = diff;
      OP_SLTU:  res_o = word_t'(lt_u);
      OP_SLT:   res_o = word_t'(lt_s);
      OP_MAXU:  res_o = lt_u ? b_i : a_i;
      OP_MINU:  res_o = lt_u ? a_i : b_i;
      OP_MAX:   res_o = lt_s ? b_i : a_i;
      OP_MIN:   res_o = lt_s ? a_i : b_i;
      default: begin
        res_o = '0;
        hit_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (op_i == OP_SLT || op_i == OP_SLTU)
      assert_slt_boolean_R7: assert (res_o[XLEN-1:1] == '0);
  end
endmodule

// File: rtl/bm_alu_logic.sv
module bm_alu_logic
  import bm_alu_pkg::*;
(
  input  op_t   op_i,
  input  word_t a_i,
  input  word_t b_i,
  output word_t res_o,
  output logic  hit_o
);
  word_t orcb, rev;
  word_t nar_val;
  logic  nar_ok;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign orcb[8*i +: 8] = {8{|a_i[8*i +: 8]}};
    assign rev[8*i +: 8]  = a_i[8*(NBYTE-1-i) +: 8];
  end

  always_comb begin
    nar_ok = 1'b1;
    unique case (op_i[3:1])
      NSEL_AND:  nar_val = a_i & b_i;
      NSEL_OR:   nar_val = a_i | b_i;
      NSEL_XOR:  nar_val = a_i ^ b_i;
      NSEL_ORCB: nar_val = orcb;
      default: begin
        nar_val = '0;
        nar_ok  = 1'b0;
      end
    endcase
  end

  always_comb begin
    hit_o = 1'b1;
    if (op_i[6:4] == GRP_NARROW) begin
      hit_o = nar_ok;
      res_o = op_i[0] ? {{(XLEN-16){1'b0}}, nar_val[15:0]}
                      : word_t'(nar_val[0]);
    end else begin
      unique case (op_i)
        OP_AND:   res_o = a_i & b_i;
        OP_ANDN:  res_o = a_i & ~b_i;
        OP_OR:    res_o = a_i | b_i;
        OP_ORN:   res_o = a_i | ~b_i;
        OP_XOR:   res_o = a_i ^ b_i;
        OP_XNOR:  res_o = ~(a_i ^ b_i);
        OP_ORCB:  res_o = orcb;
        OP_SEXTB: res_o = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
        OP_SEXTH: res_o = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
        OP_REV8:  res_o = rev;
        default: begin
          res_o = '0;
          hit_o = 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    if (op_i[6:4] == GRP_NARROW && !op_i[0])
      assert_narrow_lsb_R11: assert (res_o[XLEN-1:1] == '0);
    if (op_i[6:4] == GRP_NARROW && op_i[0])
      assert_narrow_half_R11: assert (res_o[XLEN-1:16] == '0);
  end
endmodule

// File: rtl/bm_alu_branch.sv
module bm_alu_branch
  import bm_alu_pkg::*;
(
  input  op_t   op_i,
  input  word_t a_i,
  input  word_t b_i,
  output logic  taken_o,
  output logic  hit_o
);
  logic raw;

  always_comb begin
    hit_o = (op_i[6:4] == GRP_BRANCH) && !op_i[0];
    unique case (op_i[3:2])
      2'b00:   raw = a_i == b_i;
      2'b10:   raw = $signed(a_i) < $signed(b_i);
      2'b11:   raw = a_i < b_i;
      default: begin
        raw   = 1'b0;
        hit_o = 1'b0;
      end
    endcase
    taken_o = hit_o & (raw ^ op_i[1]);
  end
endmodule

// File: rtl/bm_alu64.sv
module bm_alu64
  import bm_alu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            taken_o
);
  word_t sh_res, ar_res, lg_res, res_d;
  logic  sh_hit, ar_hit, lg_hit, br_hit, br_taken;
  logic  valid_q, taken_q;
  word_t res_q;

  bm_alu_shift u_shift (.op_i(op_i), .a_i(src_a_i), .b_i(src_b_i), .res_o(sh_res), .hit_o(sh_hit));
  bm_alu_arith u_arith (.op_i(op_i), .a_i(src_a_i), .b_i(src_b_i), .res_o(ar_res), .hit_o(ar_hit));
  bm_alu_logic u_logic (.op_i(op_i), .a_i(src_a_i), .b_i(src_b_i), .res_o(lg_res), .hit_o(lg_hit));
  bm_alu_branch u_branch (.op_i(op_i), .a_i(src_a_i), .b_i(src_b_i), .taken_o(br_taken), .hit_o(br_hit));

  // units drive zero when they do not own the opcode
  assign res_d = sh_res | ar_res | lg_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q   <= res_d;
        taken_q <= br_taken;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign taken_o  = taken_q;

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(taken_o));
  assert_unit_exclusive_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sh_hit, ar_hit, lg_hit, br_hit}));
  assert_unknown_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !(sh_hit || ar_hit || lg_hit || br_hit) |=> result_o == '0 && !taken_o);
  assert_taken_branch_only_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[6:4] != GRP_BRANCH |=> !taken_o);
  assert_branch_result_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && br_hit |=> result_o == '0);
endmodule

// File: tb/bm_alu64_test.sv
`timescale 1ns/1ps
module bm_alu64_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [6:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o, taken_o;
  logic [63:0] result_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bm_alu64 uut (.clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
                .src_a_i(a_i), .src_b_i(b_i), .valid_o(valid_o),
                .result_o(result_o), .taken_o(taken_o));

  function automatic string req_of(input logic [6:0] op);
    case (op[6:4])
      3'b000: return (op == 7'h02 || op == 7'h03 || op == 7'h04 || op == 7'h06) ? "R3" : "R2";
      3'b001: return op[3] ? "R5" : "R4";
      3'b010: return "R6";
      3'b011: return (op[2] ? "R8" : "R7");
      3'b100: return op[3] ? "R10" : "R9";
      3'b101: return "R10";
      3'b110: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] orcb_f(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = (v[8*i +: 8] != 0) ? 8'hFF : 8'h00;
    return r;
  endfunction

  task automatic ref_model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] r, output logic t, output bit known);
    int s = int'(b[5:0]);
    int sw = int'(b[4:0]);
    logic [63:0] au = {32'd0, a[31:0]};
    logic [31:0] w;
    logic [63:0] v;
    r = '0; t = 1'b0; known = 1;
    case (op)
      7'h01: r = a << s;
      7'h05: r = a >> s;
      7'h07: r = $signed(a) >>> s;
      7'h09: r = (s == 0) ? a : ((a << s) | (a >> (64 - s)));
      7'h0B: r = (s == 0) ? a : ((a >> s) | (a << (64 - s)));
      7'h02: begin r = a; r[s] = 1'b0; end
      7'h03: begin r = a; r[s] = 1'b1; end
      7'h04: begin r = a; r[s] = ~a[s]; end
      7'h06: r = {63'd0, a[s]};
      7'h10: begin w = a[31:0] + b[31:0]; r = sx32(w); end
      7'h12: begin w = a[31:0] - b[31:0]; r = sx32(w); end
      7'h18: begin w = a[31:0] << sw; r = sx32(w); end
      7'h19: begin w = a[31:0] >> sw; r = sx32(w); end
      7'h1A: begin w = $signed(a[31:0]) >>> sw; r = sx32(w); end
      7'h20: r = au + b;
      7'h21: r = a + b;
      7'h28: r = au * 2 + b;
      7'h29: r = a * 2 + b;
      7'h2A: r = au * 4 + b;
      7'h2B: r = a * 4 + b;
      7'h2C: r = au * 8 + b;
      7'h2D: r = a * 8 + b;
      7'h30: r = a - b;
      7'h31: r = (a < b) ? 64'd1 : 64'd0;
      7'h32: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'h34: r = (a > b) ? a : b;
      7'h35: r = (a < b) ? a : b;
      7'h36: r = ($signed(a) > $signed(b)) ? a : b;
      7'h37: r = ($signed(a) < $signed(b)) ? a : b;
      7'h40: r = a & b;
      7'h41: r = a & ~b;
      7'h42: r = a | b;
      7'h43: r = a | ~b;
      7'h44: r = a ^ b;
      7'h45: r = ~(a ^ b);
      7'h46: r = orcb_f(a);
      7'h48: r = {{56{a[7]}}, a[7:0]};
      7'h4A: r = {{48{a[15]}}, a[15:0]};
      7'h51: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*(7-i) +: 8];
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
        case (op[2:1])
          2'd0: v = a & b;
          2'd1: v = a | b;
          2'd2: v = a ^ b;
          default: v = orcb_f(a);
        endcase
        r = op[0] ? {48'd0, v[15:0]} : {63'd0, v[0]};
      end
      7'h70: t = (a == b);
      7'h72: t = (a != b);
      7'h78: t = ($signed(a) < $signed(b));
      7'h7A: t = ($signed(a) >= $signed(b));
      7'h7C: t = (a < b);
      7'h7E: t = (a >= b);
      default: known = 0;
    endcase
  endtask

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    logic et;
    bit kn;
    ref_model(op, a, b, er, et, kn);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    check(kn ? req_of(op) : "R13", $sformatf("op=%b result", op), result_o, er);
    check(kn ? req_of(op) : "R13", $sformatf("op=%b taken", op), {63'd0, taken_o}, {63'd0, et});
    check("R1", "valid_o after request", {63'd0, valid_o}, 64'd1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    done = 1;
  end

  initial begin
    logic [63:0] corner [8];
    logic [63:0] hr;
    logic ht;
    void'($urandom(32'd1234));
    corner[0] = 64'd0;
    corner[1] = '1;
    corner[2] = 64'h8000_0000_0000_0000;
    corner[3] = 64'd63;
    corner[4] = 64'd32;
    corner[5] = 64'd31;
    corner[6] = 64'h0000_0000_8000_0000;
    corner[7] = 64'h7FFF_FFFF_FFFF_FFFF;

    repeat (3) @(negedge clk);
    check("R1", "reset valid_o", {63'd0, valid_o}, 64'd0);
    check("R1", "reset result_o", result_o, 64'd0);
    check("R1", "reset taken_o", {63'd0, taken_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: rotate by 0 and 63, word shift with bit 5 of amount set
    run_op(7'h09, 64'h0123_4567_89AB_CDEF, 64'd0);
    run_op(7'h0B, 64'h0123_4567_89AB_CDEF, 64'd63);
    run_op(7'h18, 64'h0000_0000_4000_0001, 64'd33);
    run_op(7'h1A, 64'hFFFF_FFFF_8000_0000, 64'd63);
    run_op(7'h78, 64'h8000_0000_0000_0000, 64'd1);
    run_op(7'h7C, 64'h8000_0000_0000_0000, 64'd1);

    for (int op = 0; op < 128; op++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(7'(op), corner[i], corner[j]);
      for (int k = 0; k < 24; k++)
        run_op(7'(op), {$urandom, $urandom}, (k % 3 == 0) ? {$urandom, $urandom} : 64'($urandom % 64));
      // equal operands exercise equality branches
      begin
        logic [63:0] x = {$urandom, $urandom};
        run_op(7'(op), x, x);
      end
    end

    // idle cycles with changed inputs must not disturb outputs
    run_op(7'h7A, 64'd5, 64'd2);
    hr = result_o; ht = taken_o;
    valid_i = 1'b0; op_i = 7'h21; a_i = 64'd9; b_i = 64'd9;
    @(negedge clk);
    check("R1", "valid_o idle", {63'd0, valid_o}, 64'd0);
    check("R1", "result holds idle", result_o, hr);
    check("R1", "taken holds idle", {63'd0, taken_o}, {63'd0, ht});
    op_i = 7'h70;
    @(negedge clk);
    check("R1", "taken holds idle branch", {63'd0, taken_o}, {63'd0, ht});

    done = 1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule